// File: doc/BRIEF.md
# Sv32 Two-Level Page Table Walker

This block turns a 32-bit virtual data address into a physical address using the Sv32 two-level page table scheme. A translation request carries the virtual address, the current address-translation register value (mode in bit 31, root table page number in bits 21:0) and the privilege level. The walker fetches page table entries one word at a time through a simple request/response memory port. It returns the physical address, a fault flag and every page table entry it consulted. Entries it never read are reported as zero.

Machine mode, and a translation register whose mode bit is clear, skip the walk: the virtual address is returned unchanged after one cycle and no memory read is made. Otherwise the walker reads the level-1 entry. That entry may be a megapage leaf, an invalid entry or a pointer to a level-0 table. Only a pointer leads to the second read. The result is held at the outputs until the next request is accepted, and a one-cycle completion pulse marks when it becomes valid.

Top module: `sv32_page_walker`

## Requirements
- R1: When `priv_i` is 3 (machine) or `satp_i[31]` is 0 (bare), the result is `paddr_o` equal to `va_i` zero-extended, `fault_o` low and all four PTE outputs zero, and no memory read is issued.
- R2: The first memory read of a translated request is at address `{satp_i[21:0], va_i[31:22], 2'b00}` (34 bits).
- R3: When the level-1 entry has V (bit 0) set and both R (bit 1) and X (bit 3) clear, a second read is issued at `{pte1[31:10], va[21:12], 2'b00}`.
- R4: When the level-1 entry has V clear, R set or X set, no second read is issued and `pte0_o` reports zero.
- R5: A valid level-0 leaf (V set, and R or X set) gives `paddr_o = {pte0[31:10], va[11:0]}` zero-extended to 64 bits, with no fault.
- R6: A valid level-1 leaf gives `paddr_o = {pte1[31:20], va[21:0]}`; if `pte1[19:10]` is nonzero the superpage is misaligned and the result is a fault.
- R7: A fault is reported when the level-1 entry is invalid or the level-0 entry is invalid or not a leaf; every faulting result has `paddr_o` zero.
- R8: `pte2_o` and `pte3_o` are always zero, and `pte1_o` reports the level-1 entry whenever one was read.
- R9: `mem_req_valid_o` stays high with a stable address until `mem_req_ready_i`, and is never high while the walker is idle.
- R10: `done_o` is a single-cycle pulse, `req_ready_o` is high only while idle, and the result outputs hold their values until the next completion.
- R11: A bypassed request raises `done_o` in the cycle directly after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle and accepting a request |
| va_i | input | 32 | Virtual address |
| satp_i | input | 32 | Translation register: mode bit 31, root PPN bits 21:0 |
| priv_i | input | 2 | Privilege level, 3 is machine |
| mem_req_valid_o | output | 1 | Memory word read request |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 34 | Byte address of the PTE word |
| mem_resp_valid_i | input | 1 | Read data returned |
| mem_resp_data_i | input | 32 | Read data word |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Translation fault |
| paddr_o | output | 64 | Physical address, zero-extended |
| pte0_o | output | 32 | Level-0 entry used, or zero |
| pte1_o | output | 32 | Level-1 entry used, or zero |
| pte2_o | output | 32 | Always zero |
| pte3_o | output | 32 | Always zero |

## Verification
The assertions assume the memory side returns exactly one response per accepted read, never earlier than the cycle after the handshake, and that the requester offers a new request only while the walker shows ready. The bench's responder answers each handshake in the following cycle and gates its ready with a pseudo-random pattern, so stalls are exercised without breaking that order. Requests are issued only after the previous completion has been observed, so the walker is never asked to take a request while busy.

// File: rtl/sv32_walk_pkg.sv
package sv32_walk_pkg;

    localparam int VA_W       = 32;
    localparam int PTE_W      = 32;
    localparam int PA_W       = 34;
    localparam int PA_OUT_W   = 64;
    localparam int PPN_W      = 22;
    localparam int PPN1_W     = 12;
    localparam int VPN_W      = 10;
    localparam int PG_OFS_W   = 12;
    localparam int MEGA_OFS_W = VPN_W + PG_OFS_W;
    localparam int MODE_BIT   = 31;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_L1_REQ,
        WK_L1_WAIT,
        WK_L0_REQ,
        WK_L0_WAIT,
        WK_DONE
    } walk_state_e;

    typedef struct packed {
        logic             valid;
        logic             is_leaf;
        logic             is_ptr;
        logic             lo_ppn_zero;
        logic [PPN_W-1:0] ppn;
    } pte_info_t;

    typedef struct packed {
        logic             fault;
        logic [PA_W-1:0]  pa;
        logic [PTE_W-1:0] pte1;
        logic [PTE_W-1:0] pte0;
    } walk_result_t;

    function automatic logic [PA_W-1:0] table_entry_addr(
        input logic [PPN_W-1:0] base,
        input logic [VPN_W-1:0] idx
    );
        return {base, idx, 2'b00};
    endfunction

    function automatic logic needs_walk(
        input logic [VA_W-1:0] satp,
        input logic [1:0]      priv
    );
        return satp[MODE_BIT] && (priv != PRIV_MACHINE);
    endfunction

endpackage

// File: rtl/sv32_pte_decode.sv
module sv32_pte_decode
    import sv32_walk_pkg::*;
(
    input  logic [PTE_W-1:0] pte_i,
    output pte_info_t        info_o
);
    localparam int V_BIT = 0;
    localparam int R_BIT = 1;
    localparam int X_BIT = 3;
    localparam int PPN_LSB = 10;

    always_comb begin
        info_o.valid       = pte_i[V_BIT];
        info_o.is_leaf     = pte_i[V_BIT] && (pte_i[R_BIT] || pte_i[X_BIT]);
        info_o.is_ptr      = pte_i[V_BIT] && !pte_i[R_BIT] && !pte_i[X_BIT];
        info_o.ppn         = pte_i[PTE_W-1:PPN_LSB];
        info_o.lo_ppn_zero = (pte_i[PPN_LSB+VPN_W-1:PPN_LSB] == '0);
    end
endmodule

// File: rtl/sv32_walk_addr.sv
module sv32_walk_addr
    import sv32_walk_pkg::*;
(
    input  logic [VA_W-1:0]  va_q_i,
    input  logic [VA_W-1:0]  satp_q_i,
    input  logic [PTE_W-1:0] pte1_q_i,
    input  logic [PTE_W-1:0] resp_pte_i,
    output logic [PA_W-1:0]  l1_addr_o,
    output logic [PA_W-1:0]  l0_addr_o,
    output logic [PA_W-1:0]  mega_pa_o,
    output logic [PA_W-1:0]  page_pa_o
);
    logic [VPN_W-1:0] vpn_hi;
    logic [VPN_W-1:0] vpn_lo;

    always_comb begin
        vpn_hi    = va_q_i[VA_W-1 -: VPN_W];
        vpn_lo    = va_q_i[PG_OFS_W +: VPN_W];
        l1_addr_o = table_entry_addr(satp_q_i[PPN_W-1:0], vpn_hi);
        l0_addr_o = table_entry_addr(pte1_q_i[PTE_W-1 -: PPN_W], vpn_lo);
        mega_pa_o = {resp_pte_i[PTE_W-1 -: PPN1_W], va_q_i[MEGA_OFS_W-1:0]};
        page_pa_o = {resp_pte_i[PTE_W-1 -: PPN_W], va_q_i[PG_OFS_W-1:0]};
    end
endmodule

// File: rtl/sv32_walk_ctrl.sv
module sv32_walk_ctrl
    import sv32_walk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid_i,
    input  logic [VA_W-1:0]  va_i,
    input  logic [VA_W-1:0]  satp_i,
    input  logic [1:0]       priv_i,
    input  logic             mem_req_ready_i,
    input  logic             mem_resp_valid_i,
    input  logic [PTE_W-1:0] mem_resp_data_i,
    input  pte_info_t        resp_info_i,
    input  logic [PA_W-1:0]  l1_addr_i,
    input  logic [PA_W-1:0]  l0_addr_i,
    input  logic [PA_W-1:0]  mega_pa_i,
    input  logic [PA_W-1:0]  page_pa_i,
    output logic [VA_W-1:0]  va_q_o,
    output logic [VA_W-1:0]  satp_q_o,
    output logic [PTE_W-1:0] pte1_q_o,
    output logic             req_ready_o,
    output logic             mem_req_valid_o,
    output logic [PA_W-1:0]  mem_req_addr_o,
    output logic             done_o,
    output walk_result_t     result_o
);
    walk_state_e  state_q, state_n;
    walk_result_t res_q, res_n;
    logic [VA_W-1:0]  va_q, satp_q;
    logic [PTE_W-1:0] pte1_q;
    logic             accept;
    logic [PA_W-1:0]  va_as_pa;

    assign accept   = (state_q == WK_IDLE) && req_valid_i;
    assign va_as_pa = {{(PA_W-VA_W){1'b0}}, va_i};

    always_comb begin
        state_n = state_q;
        res_n   = res_q;
        unique case (state_q)
            WK_IDLE: begin
                if (req_valid_i) begin
                    if (needs_walk(satp_i, priv_i)) begin
                        state_n = WK_L1_REQ;
                    end else begin
                        res_n   = '{fault: 1'b0, pa: va_as_pa, pte1: '0, pte0: '0};
                        state_n = WK_DONE;
                    end
                end
            end
            WK_L1_REQ: if (mem_req_ready_i) state_n = WK_L1_WAIT;
            WK_L1_WAIT: begin
                if (mem_resp_valid_i) begin
                    if (!resp_info_i.valid) begin
                        res_n   = '{fault: 1'b1, pa: '0, pte1: mem_resp_data_i, pte0: '0};
                        state_n = WK_DONE;
                    end else if (resp_info_i.is_leaf) begin
                        if (resp_info_i.lo_ppn_zero) begin
                            res_n = '{fault: 1'b0, pa: mega_pa_i, pte1: mem_resp_data_i, pte0: '0};
                        end else begin
                            res_n = '{fault: 1'b1, pa: '0, pte1: mem_resp_data_i, pte0: '0};
                        end
                        state_n = WK_DONE;
                    end else begin
                        state_n = WK_L0_REQ;
                    end
                end
            end
            WK_L0_REQ: if (mem_req_ready_i) state_n = WK_L0_WAIT;
            WK_L0_WAIT: begin
                if (mem_resp_valid_i) begin
                    if (resp_info_i.is_leaf) begin
                        res_n = '{fault: 1'b0, pa: page_pa_i, pte1: pte1_q, pte0: mem_resp_data_i};
                    end else begin
                        res_n = '{fault: 1'b1, pa: '0, pte1: pte1_q, pte0: mem_resp_data_i};
                    end
                    state_n = WK_DONE;
                end
            end
            WK_DONE: state_n = WK_IDLE;
            default: state_n = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WK_IDLE;
            res_q   <= '0;
            va_q    <= '0;
            satp_q  <= '0;
            pte1_q  <= '0;
        end else begin
            state_q <= state_n;
            res_q   <= res_n;
            if (accept) begin
                va_q   <= va_i;
                satp_q <= satp_i;
            end
            if (state_q == WK_L1_WAIT && mem_resp_valid_i) begin
                pte1_q <= mem_resp_data_i;
            end
        end
    end

    assign va_q_o          = va_q;
    assign satp_q_o        = satp_q;
    assign pte1_q_o        = pte1_q;
    assign req_ready_o     = (state_q == WK_IDLE);
    assign mem_req_valid_o = (state_q == WK_L1_REQ) || (state_q == WK_L0_REQ);
    assign mem_req_addr_o  = (state_q == WK_L0_REQ) ? l0_addr_i : l1_addr_i;
    assign done_o          = (state_q == WK_DONE);
    assign result_o        = res_q;
endmodule

// File: rtl/sv32_page_walker.sv
module sv32_page_walker
    import sv32_walk_pkg::*;
#(
    parameter int OUT_PA_W = PA_OUT_W,
    parameter int SPARE_PTES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid_i,
    output logic                req_ready_o,
    input  logic [VA_W-1:0]     va_i,
    input  logic [VA_W-1:0]     satp_i,
    input  logic [1:0]          priv_i,
    output logic                mem_req_valid_o,
    input  logic                mem_req_ready_i,
    output logic [PA_W-1:0]     mem_req_addr_o,
    input  logic                mem_resp_valid_i,
    input  logic [PTE_W-1:0]    mem_resp_data_i,
    output logic                done_o,
    output logic                fault_o,
    output logic [OUT_PA_W-1:0] paddr_o,
    output logic [PTE_W-1:0]    pte0_o,
    output logic [PTE_W-1:0]    pte1_o,
    output logic [PTE_W-1:0]    pte2_o,
    output logic [PTE_W-1:0]    pte3_o
);
    localparam int PAD_W = OUT_PA_W - PA_W;

    pte_info_t        resp_info;
    walk_result_t     result;
    logic [VA_W-1:0]  va_q, satp_q;
    logic [PTE_W-1:0] pte1_q;
    logic [PA_W-1:0]  l1_addr, l0_addr, mega_pa, page_pa;
    logic [PTE_W-1:0] upper_ptes [SPARE_PTES];

    sv32_pte_decode u_resp_decode (
        .pte_i  (mem_resp_data_i),
        .info_o (resp_info)
    );

    sv32_walk_addr u_addr (
        .va_q_i     (va_q),
        .satp_q_i   (satp_q),
        .pte1_q_i   (pte1_q),
        .resp_pte_i (mem_resp_data_i),
        .l1_addr_o  (l1_addr),
        .l0_addr_o  (l0_addr),
        .mega_pa_o  (mega_pa),
        .page_pa_o  (page_pa)
    );

    sv32_walk_ctrl u_ctrl (
        .clk              (clk),
        .rst              (rst),
        .req_valid_i      (req_valid_i),
        .va_i             (va_i),
        .satp_i           (satp_i),
        .priv_i           (priv_i),
        .mem_req_ready_i  (mem_req_ready_i),
        .mem_resp_valid_i (mem_resp_valid_i),
        .mem_resp_data_i  (mem_resp_data_i),
        .resp_info_i      (resp_info),
        .l1_addr_i        (l1_addr),
        .l0_addr_i        (l0_addr),
        .mega_pa_i        (mega_pa),
        .page_pa_i        (page_pa),
        .va_q_o           (va_q),
        .satp_q_o         (satp_q),
        .pte1_q_o         (pte1_q),
        .req_ready_o      (req_ready_o),
        .mem_req_valid_o  (mem_req_valid_o),
        .mem_req_addr_o   (mem_req_addr_o),
        .done_o           (done_o),
        .result_o         (result)
    );

    // Sv32 has two levels; the deeper slots exist only for a uniform result shape.
    for (genvar g = 0; g < SPARE_PTES; g++) begin : g_spare
        assign upper_ptes[g] = '0;
    end

    assign fault_o = result.fault;
    assign paddr_o = {{PAD_W{1'b0}}, result.pa};
    assign pte0_o  = result.pte0;
    assign pte1_o  = result.pte1;
    assign pte2_o  = upper_ptes[0];
    assign pte3_o  = upper_ptes[SPARE_PTES-1];
endmodule

// File: rtl/sv32_page_walker_chk.sv
module sv32_page_walker_chk
    import sv32_walk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid_i,
    input logic             req_ready_o,
    input logic [VA_W-1:0]  va_i,
    input logic [VA_W-1:0]  satp_i,
    input logic [1:0]       priv_i,
    input logic             mem_req_valid_o,
    input logic             mem_req_ready_i,
    input logic [PA_W-1:0]  mem_req_addr_o,
    input logic             done_o,
    input logic             fault_o,
    input logic [63:0]      paddr_o,
    input logic [PTE_W-1:0] pte0_o,
    input logic [PTE_W-1:0] pte1_o
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)); // R9

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid_o |-> !req_ready_o); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(paddr_o) && $stable(fault_o) && $stable(pte1_o) && $stable(pte0_o)); // R10

    AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (rst)
        req_valid_i && req_ready_o && (priv_i == PRIV_MACHINE || !satp_i[MODE_BIT])
        |=> done_o && !fault_o && paddr_o == {32'b0, $past(va_i)} && pte1_o == '0 && pte0_o == '0); // R11

    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
        done_o && fault_o |-> paddr_o == '0); // R7

    AST_SKIP_PTE0: assert property (@(posedge clk) disable iff (rst)
        done_o && (!pte1_o[0] || pte1_o[1] || pte1_o[3]) |-> pte0_o == '0); // R4
endmodule

bind sv32_page_walker sv32_page_walker_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .va_i            (va_i),
    .satp_i          (satp_i),
    .priv_i          (priv_i),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .done_o          (done_o),
    .fault_o         (fault_o),
    .paddr_o         (paddr_o),
    .pte0_o          (pte0_o),
    .pte1_o          (pte1_o)
);

// File: tb/sv32_page_walker_bench.sv
`timescale 1ns/1ps
module sv32_page_walker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [31:0] va_i = '0;
    logic [31:0] satp_i = '0;
    logic [1:0]  priv_i = '0;
    logic        mem_req_valid_o;
    logic        mem_req_ready_i = 1'b0;
    logic [33:0] mem_req_addr_o;
    logic        mem_resp_valid_i = 1'b0;
    logic [31:0] mem_resp_data_i = '0;
    logic        done_o, fault_o;
    logic [63:0] paddr_o;
    logic [31:0] pte0_o, pte1_o, pte2_o, pte3_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [31:0] mem [4096];
    int          n_reads;
    logic [33:0] addr_log [2];

    always #2 clk = ~clk;

    sv32_page_walker u_sv32_page_walker (.*);

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory responder: answers each handshake in the following cycle
    initial begin
        logic [15:0] lfsr = 16'hACE1;
        bit          pend = 0;
        logic [31:0] rd = '0;
        forever begin
            @(negedge clk);
            mem_resp_valid_i = 1'b0;
            if (pend) begin
                mem_resp_valid_i = 1'b1;
                mem_resp_data_i  = rd;
                pend = 0;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_req_ready_i = lfsr[0] | lfsr[1];
            if (mem_req_valid_o && mem_req_ready_i && !rst) begin
                pend = 1;
                rd = mem[mem_req_addr_o[13:2]];
                if (n_reads < 2) addr_log[n_reads] = mem_req_addr_o;
                n_reads++;
            end
        end
    end

    task automatic run_walk(input logic [31:0] va, input logic [31:0] satp, input logic [1:0] pr);
        bit byp;
        logic [33:0] a0, a1;
        logic [31:0] p1, p0, e1, e0;
        logic [63:0] epa, held;
        bit ef;
        int ereads, waited;
        byp = (pr == 2'd3) || !satp[31];
        a0 = {satp[21:0], va[31:22], 2'b00};
        a1 = '0; e1 = '0; e0 = '0; ef = 0; epa = '0; ereads = 0;
        if (byp) begin
            epa = {32'b0, va};
        end else begin
            p1 = mem[a0[13:2]]; ereads = 1; e1 = p1;
            if (!p1[0]) begin
                ef = 1;
            end else if (p1[1] || p1[3]) begin
                if (p1[19:10] != 0) ef = 1;
                else epa = {30'b0, p1[31:20], va[21:0]};
            end else begin
                a1 = {p1[31:10], va[21:12], 2'b00};
                p0 = mem[a1[13:2]]; ereads = 2; e0 = p0;
                if (!p0[0] || !(p0[1] || p0[3])) ef = 1;
                else epa = {30'b0, p0[31:10], va[11:0]};
            end
        end
        @(negedge clk);
        n_reads = 0;
        req_valid_i = 1'b1; va_i = va; satp_i = satp; priv_i = pr;
        @(negedge clk);
        req_valid_i = 1'b0;
        waited = 0;
        while (!done_o && waited < 64) begin
            @(negedge clk);
            waited++;
        end
        chk("R10", "completion seen", {63'b0, done_o}, 64'd1);
        if (byp) begin
            chk("R11", "bypass latency", waited, 0);
            chk("R1", "bypass reads", n_reads, 0);
            chk("R1", "bypass paddr", paddr_o, epa);
            chk("R1", "bypass ptes", {pte1_o, pte0_o}, 64'd0);
        end else begin
            chk("R2", "level-1 address", addr_log[0], a0);
            if (ereads == 2) chk("R3", "level-0 address", addr_log[1], a1);
            else chk("R4", "level-0 skipped", n_reads, ereads);
            chk(ereads == 2 ? "R3" : "R4", "read count", n_reads, ereads);
            chk(ef ? "R7" : (ereads == 2 ? "R5" : "R6"), "fault", fault_o, ef);
            chk(ef ? "R7" : (ereads == 2 ? "R5" : "R6"), "paddr", paddr_o, epa);
            chk("R8", "pte1", pte1_o, e1);
            chk(ereads == 2 ? "R3" : "R4", "pte0", pte0_o, e0);
        end
        chk("R8", "pte2/pte3", {pte2_o, pte3_o}, 64'd0);
        held = paddr_o;
        @(negedge clk);
        chk("R10", "done single pulse", done_o, 0);
        @(negedge clk);
        chk("R10", "paddr held", paddr_o, held);
        chk("R10", "ready when idle", req_ready_o, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4096; k++) mem[k] = '0;
        // level-1 table at 0x1000 (root PPN 1)
        for (int i = 0; i < 8; i++) begin
            case (i % 4)
                0: mem[12'h400 + i] = 32'h0030_000E;
                1: mem[12'h400 + i] = ((i == 5) ? 32'd3 : 32'd2) << 10 | 32'h1;
                2: mem[12'h400 + i] = ((32'h100 + i) << 20) | 32'hF;
                default: mem[12'h400 + i] = (i << 20) | (32'd5 << 10) | 32'h3;
            endcase
        end
        // level-0 tables at 0x2000 and 0x3000
        for (int t = 2; t < 4; t++) begin
            for (int j = 0; j < 8; j++) begin
                case (j % 3)
                    0: mem[t * 1024 + j] = 32'h0000_0C06;
                    1: mem[t * 1024 + j] = ((32'h2A000 + t * 64 + j) << 10) | 32'h7;
                    default: mem[t * 1024 + j] = 32'h0000_0401;
                endcase
            end
            mem[t * 1024 + 4] = ((32'h15500 + t) << 10) | 32'h9;
        end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "reset ready", req_ready_o, 1);
        chk("R10", "reset done", done_o, 0);
        chk("R9", "reset mem request", mem_req_valid_o, 0);
        chk("R7", "reset fault", fault_o, 0);
        chk("R1", "reset paddr", paddr_o, 0);

        // bypass: machine mode with translation on, and bare mode
        run_walk(32'h0040_5123, 32'h8A40_0001, 2'd3);
        run_walk(32'hFFFF_FFFF, 32'h8A40_0001, 2'd3);
        run_walk(32'h1234_5678, 32'h0000_0001, 2'd0);
        run_walk(32'h8000_0000, 32'h0000_0001, 2'd1);

        // translated sweep
        for (int v1 = 0; v1 < 8; v1++) begin
            for (int v0 = 0; v0 < 8; v0++) begin
                for (int o = 0; o < 3; o++) begin
                    logic [11:0] ofs;
                    ofs = (o == 0) ? 12'h000 : (o == 1) ? 12'h5A4 : 12'hFFF;
                    run_walk({v1[9:0], v0[9:0], ofs}, 32'h8A40_0001, ((v0 + o) % 2 == 0) ? 2'd0 : 2'd1);
                end
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule